// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects five interrupt request lines that have a fixed order of precedence and, at each instruction boundary, grants the most urgent one that may be taken. One line cannot be masked. Three lines are maskable and vectored: a grant on one of them emits a fixed 16-bit vector address. One line is maskable and non-vectored: a grant on it drives an active-low acknowledge, so that an external device can place an instruction on the bus.

Each line has its own trigger style. The non-maskable line needs a rising edge, and the line must then stay high until it is granted. The highest maskable line latches a rising edge, so a short pulse is not lost. The other three lines are level-sensitive. All raw inputs pass through a two-flop synchronizer. A global enable flag gates every maskable line. A mask word holds a separate mask for each vectored maskable line. A bit in the same mask word clears the edge latch. The processor core drives an instruction-boundary strobe and the enable, disable and mask-write operations. Stack handling and instruction execution stay in the core.

Top module: `pvic_top`

## Requirements
- R1: After reset, grant_valid_o is 0, ext_ack_n_o is 1, vector_o is 0, the global enable is clear, all masks are clear (unmasked) and no request is pending, so only the non-maskable line can be granted.
- R2: When several requests may be granted at once, precedence from highest to lowest is: req_nmi_i, req_edge_i, req_lvl_hi_i, req_lvl_lo_i, req_ext_i.
- R3: A vectored grant places its vector on vector_o: req_nmi_i gives 16'h0024, req_edge_i gives 16'h003C, req_lvl_hi_i gives 16'h0034 and req_lvl_lo_i gives 16'h002C. vector_o is 0 in every other cycle.
- R4: req_nmi_i is granted whatever the enable flag and the masks hold. A grant needs a rising edge followed by the line staying high until the boundary. If the line falls before the boundary, the request is dropped. A held-high line is granted only once per rising edge.
- R5: A rising edge on req_edge_i is latched even when the pulse is a single cycle long. The latch clears when req_edge_i is granted, or when mask_wr_i is high with mask_data_i[3] = 1.
- R6: req_lvl_hi_i, req_lvl_lo_i and req_ext_i count as requests only while their synchronized level is high. Nothing is remembered for them.
- R7: When mask_wr_i is high, mask_data_i[2] masks req_edge_i, mask_data_i[1] masks req_lvl_hi_i and mask_data_i[0] masks req_lvl_lo_i. A mask bit of 1 blocks its grant.
- R8: ei_i sets the global enable and di_i clears it. When both are high in the same cycle, di_i wins. While the enable is clear, no maskable line is granted. di_i leaves the req_edge_i latch intact.
- R9: A grant happens only in a cycle with boundary_i high. Its output shows up one clock edge later and lasts exactly one cycle.
- R10: A grant of req_ext_i drives ext_ack_n_o low for one cycle. For that grant, grant_valid_o stays 0 and vector_o stays 0.
- R11: Every grant of a maskable line clears the global enable. A grant of req_nmi_i leaves the enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_nmi_i | input | 1 | Non-maskable request, edge then held level |
| req_edge_i | input | 1 | Maskable vectored request, latched rising edge |
| req_lvl_hi_i | input | 1 | Maskable vectored request, level |
| req_lvl_lo_i | input | 1 | Maskable vectored request, level |
| req_ext_i | input | 1 | Maskable non-vectored request, level |
| boundary_i | input | 1 | Instruction-boundary strobe |
| ei_i | input | 1 | Enable-interrupt operation |
| di_i | input | 1 | Disable-interrupt operation |
| mask_wr_i | input | 1 | Mask-word write strobe |
| mask_data_i | input | 4 | Mask word: [2:0] masks, [3] clears the edge latch |
| grant_valid_o | output | 1 | One-cycle pulse for a vectored grant |
| vector_o | output | 16 | Vector address of the granted line |
| ext_ack_n_o | output | 1 | Active-low acknowledge for the non-vectored line |

## Verification
A raw input change reaches the synchronized level two edges after it is sampled. The edge latch and the non-maskable pending flag are set one edge after that. The bench therefore raises its inputs and waits four full cycles before it strobes boundary_i. A grant registers on the edge that samples the strobe. The bench drives boundary_i for one cycle and reads the outputs at the falling edge that follows. It reads them again one cycle later to confirm that the pulse has ended. Operations on the enable flag and the mask word take effect on the next edge, so the bench always completes them at least one cycle before the strobe.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    localparam int NUM_SRC  = 5;
    localparam int IDX_NMI  = 0;
    localparam int IDX_EDGE = 1;
    localparam int IDX_HI   = 2;
    localparam int IDX_LO   = 3;
    localparam int IDX_EXT  = 4;
    localparam int NUM_MASK = 3;
    localparam int MASK_W   = NUM_MASK + 1;
endpackage

// File: rtl/pvic_sync.sv
module pvic_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    logic [N-1:0] gnt_d;
    logic         taken;

    always_comb begin
        gnt_d = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !taken) begin
                gnt_d[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    assign gnt_o = gnt_d;

    always_comb begin
        AST_GNT_ONEHOT: assert ($onehot0(gnt_o)); // R2
    end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int              VEC_W     = 16,
    parameter int              SYNC_LEN  = 2,
    parameter logic [VEC_W-1:0] VEC_NMI  = 16'h0024,
    parameter logic [VEC_W-1:0] VEC_EDGE = 16'h003C,
    parameter logic [VEC_W-1:0] VEC_HI   = 16'h0034,
    parameter logic [VEC_W-1:0] VEC_LO   = 16'h002C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_nmi_i,
    input  logic              req_edge_i,
    input  logic              req_lvl_hi_i,
    input  logic              req_lvl_lo_i,
    input  logic              req_ext_i,
    input  logic              boundary_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              mask_wr_i,
    input  logic [MASK_W-1:0] mask_data_i,
    output logic              grant_valid_o,
    output logic [VEC_W-1:0]  vector_o,
    output logic              ext_ack_n_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0]  prev;
        logic                nmi_pend;
        logic                edge_lat;
        logic                ie;
        logic [NUM_MASK-1:0] mask;
        logic                gvalid;
        logic                ack_n;
        logic [VEC_W-1:0]    vec;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] raw_req, sync_req, rise, cand, gnt;

    assign raw_req = {req_ext_i, req_lvl_lo_i, req_lvl_hi_i, req_edge_i, req_nmi_i};

    pvic_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_LEN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_req),
        .sync_o (sync_req)
    );

    assign rise = sync_req & ~st_q.prev;

    always_comb begin
        cand           = '0;
        cand[IDX_NMI]  = st_q.nmi_pend;
        cand[IDX_EDGE] = st_q.edge_lat & ~st_q.mask[2] & st_q.ie;
        cand[IDX_HI]   = sync_req[IDX_HI] & ~st_q.mask[1] & st_q.ie;
        cand[IDX_LO]   = sync_req[IDX_LO] & ~st_q.mask[0] & st_q.ie;
        cand[IDX_EXT]  = sync_req[IDX_EXT] & st_q.ie;
        if (!boundary_i) cand = '0;
    end

    pvic_arbiter #(.N(NUM_SRC)) u_arb (
        .req_i (cand),
        .gnt_o (gnt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.prev   = sync_req;
        st_d.gvalid = 1'b0;
        st_d.ack_n  = 1'b1;
        st_d.vec    = '0;

        st_d.nmi_pend = (st_q.nmi_pend | rise[IDX_NMI]) & sync_req[IDX_NMI] & ~gnt[IDX_NMI];
        st_d.edge_lat = (st_q.edge_lat | rise[IDX_EDGE]) & ~gnt[IDX_EDGE]
                        & ~(mask_wr_i & mask_data_i[NUM_MASK]);

        if (mask_wr_i) st_d.mask = mask_data_i[NUM_MASK-1:0];

        if (ei_i) st_d.ie = 1'b1;
        if (di_i) st_d.ie = 1'b0;
        if (|gnt[NUM_SRC-1:1]) st_d.ie = 1'b0;

        if (gnt[IDX_NMI]) begin
            st_d.gvalid = 1'b1;
            st_d.vec    = VEC_NMI;
        end else if (gnt[IDX_EDGE]) begin
            st_d.gvalid = 1'b1;
            st_d.vec    = VEC_EDGE;
        end else if (gnt[IDX_HI]) begin
            st_d.gvalid = 1'b1;
            st_d.vec    = VEC_HI;
        end else if (gnt[IDX_LO]) begin
            st_d.gvalid = 1'b1;
            st_d.vec    = VEC_LO;
        end else if (gnt[IDX_EXT]) begin
            st_d.ack_n  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ack_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid_o = st_q.gvalid;
    assign vector_o      = st_q.vec;
    assign ext_ack_n_o   = st_q.ack_n;

    AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid_o && !ext_ack_n_o)); // R10
    AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o || !ext_ack_n_o) |-> $past(boundary_i)); // R9
    AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |=> !grant_valid_o); // R9
    AST_MASKABLE_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_valid_o && vector_o != VEC_NMI) || !ext_ack_n_o) |-> !st_q.ie); // R11
    AST_EDGE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && vector_o == VEC_EDGE) |-> $past(st_q.ie && !st_q.mask[2])); // R7
    AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> (vector_o == VEC_NMI || vector_o == VEC_EDGE ||
                           vector_o == VEC_HI  || vector_o == VEC_LO)); // R3
    AST_VECTOR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid_o |-> vector_o == '0); // R3
endmodule

// File: tb/pvic_top_tb.sv
module pvic_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_nmi = 0, req_edge = 0, req_hi = 0, req_lo = 0, req_ext = 0;
    logic        boundary = 0, ei = 0, di = 0, mask_wr = 0;
    logic [3:0]  mask_data = '0;
    logic        gv;
    logic [15:0] vec;
    logic        ackn;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pvic_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_nmi_i(req_nmi), .req_edge_i(req_edge), .req_lvl_hi_i(req_hi),
        .req_lvl_lo_i(req_lo), .req_ext_i(req_ext), .boundary_i(boundary),
        .ei_i(ei), .di_i(di), .mask_wr_i(mask_wr), .mask_data_i(mask_data),
        .grant_valid_o(gv), .vector_o(vec), .ext_ack_n_o(ackn)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        req_nmi = 0; req_edge = 0; req_hi = 0; req_lo = 0; req_ext = 0;
        boundary = 0; ei = 0; di = 0; mask_wr = 0; mask_data = '0;
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
    endtask

    task automatic set_mask(input logic [3:0] m);
        mask_wr = 1; mask_data = m;
        @(negedge clk); mask_wr = 0; mask_data = '0;
    endtask

    task automatic do_ei();
        ei = 1; @(negedge clk); ei = 0;
    endtask

    // strobe one boundary, sample the registered grant, then confirm it is a single cycle
    task automatic strobe(input string req, input logic egv, input logic [15:0] evec, input logic eack);
        boundary = 1;
        @(negedge clk); boundary = 0;
        chk(req, "grant_valid", gv, egv);
        chk(req, "vector", vec, evec);
        chk(req, "ack_n", ackn, eack);
        @(negedge clk);
        chk("R9", "pulse ends", {gv, ackn}, 2'b01);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "grant_valid", gv, 0);
        chk("R1", "ack_n", ackn, 1);
        chk("R1", "vector", vec, 0);
        req_hi = 1; req_ext = 1; cyc(4);
        strobe("R1", 0, 16'h0, 1);

        // R9 no grant without the strobe
        do_reset(); do_ei(); req_hi = 1;
        for (int k = 0; k < 8; k++) begin
            cyc(1);
            chk("R9", "no strobe", {gv, ackn}, 2'b01);
        end
        strobe("R9", 1, 16'h0034, 1);

        // Sweep: all patterns of the four maskable lines, masks and enable
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 8; m++) begin
                for (int e = 0; e < 2; e++) begin
                    logic        xgv, xack;
                    logic [15:0] xvec;
                    do_reset();
                    if (m != 0) set_mask(4'(m));
                    if (e != 0) do_ei();
                    req_edge = p[0]; req_hi = p[1]; req_lo = p[2]; req_ext = p[3];
                    @(negedge clk); req_edge = 0;   // single-cycle pulse, R5
                    cyc(4);
                    xgv = 0; xack = 1; xvec = 16'h0;
                    if (e != 0) begin
                        if (p[0] && !m[2])      begin xgv = 1; xvec = 16'h003C; end
                        else if (p[1] && !m[1]) begin xgv = 1; xvec = 16'h0034; end
                        else if (p[2] && !m[0]) begin xgv = 1; xvec = 16'h002C; end
                        else if (p[3])          begin xack = 0; end
                    end
                    strobe("R2/R3/R6/R7/R8/R10", xgv, xvec, xack);
                    // R11: the enable is now clear, so nothing is taken again
                    strobe("R11", 0, 16'h0, 1);
                end
            end
        end

        // R4 non-maskable: granted with enable clear and all masks set
        do_reset(); set_mask(4'b0111);
        req_nmi = 1; cyc(4);
        strobe("R4", 1, 16'h0024, 1);
        strobe("R4", 0, 16'h0, 1);          // one grant per rising edge
        req_nmi = 0; cyc(3); req_nmi = 1; cyc(4);
        strobe("R4", 1, 16'h0024, 1);       // a new edge gives a new grant
        // R4 a line that drops before the boundary is not granted
        req_nmi = 0; cyc(3);
        req_nmi = 1; @(negedge clk); req_nmi = 0; cyc(5);
        strobe("R4", 0, 16'h0, 1);

        // R2 non-maskable wins over everything; R11 the enable survives it
        do_reset(); do_ei();
        req_nmi = 1; req_edge = 1; req_hi = 1; req_lo = 1; req_ext = 1; cyc(4);
        strobe("R2", 1, 16'h0024, 1);
        strobe("R11", 1, 16'h003C, 1);
        strobe("R2", 0, 16'h0, 1);
        req_nmi = 0;

        // R5 the latch clear bit of the mask word drops a latched edge
        do_reset(); do_ei();
        req_edge = 1; @(negedge clk); req_edge = 0; cyc(4);
        set_mask(4'b1000);
        strobe("R5", 0, 16'h0, 1);
        // R5 the latch clears on its own grant
        do_reset(); do_ei();
        req_edge = 1; @(negedge clk); req_edge = 0; cyc(4);
        strobe("R5", 1, 16'h003C, 1);
        do_ei(); cyc(1);
        strobe("R5", 0, 16'h0, 1);

        // R8 disable blocks, keeps the latch; enable then grants it
        do_reset(); do_ei();
        req_edge = 1; @(negedge clk); req_edge = 0; cyc(4);
        di = 1; @(negedge clk); di = 0;
        strobe("R8", 0, 16'h0, 1);
        do_ei();
        strobe("R8", 1, 16'h003C, 1);
        // R8 disable wins over a simultaneous enable
        do_reset(); req_lo = 1;
        ei = 1; di = 1; @(negedge clk); ei = 0; di = 0; cyc(3);
        strobe("R8", 0, 16'h0, 1);

        // R6 a level line that drops is forgotten
        do_reset(); do_ei();
        req_hi = 1; cyc(4); req_hi = 0; cyc(4);
        strobe("R6", 0, 16'h0, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule